// File: doc/BRIEF.md
# Operand Hazard and Forwarding Unit

A purely combinational unit that sits beside the decode stage of a five-stage load/store pipeline with 32 general registers. For each of the two source operands of the instruction in decode, it checks whether an older instruction still in the execute or memory stage will write that register. It then either replaces the register-file value with a value from a later stage, or asks the pipeline to hold decode for a cycle.

Dependencies are checked only against operands that the decoded instruction really consumes. Two per-instruction flags tell the unit whether the ALU or the store path reads the first source (rs) and the second source (rt). An immediate ALU operation or a load sets only the rs flag. A store sets both, because rt carries the store data. Register 0 and stages that do not write are never treated as producers. The write-back stage is not checked, since its result is already visible through the register-file read in the same cycle. A mode input selects forwarding with stalls, or stalls only.

Top module: `fwd_hazard_unit`

## Requirements
- R1: When no dependency is detected, rs_val_o and rt_val_o equal rf_rs_val_i and rf_rt_val_i, both forward codes are 2'b00, and stall_o is 0.
- R2: A stage whose destination index is 0 never causes a dependency, even if its write enable is set and a needed source index is 0.
- R3: A stage with its write enable low never causes a dependency, whatever its destination index.
- R4: rs is compared only when need_rs_i is 1, and rt only when need_rt_i is 1. A matching index on an operand that is not needed changes no output.
- R5: In forwarding mode (fwd_en_i=1), a needed operand that matches the memory stage takes mem_wb_val_i with forward code 2'b01.
- R6: In forwarding mode, a needed operand that matches a non-load in the execute stage takes ex_alu_val_i with forward code 2'b10.
- R7: When both the execute stage (non-load) and the memory stage match the same operand, the execute-stage value and code 2'b10 win.
- R8: In forwarding mode, a needed operand that matches a load in the execute stage sets stall_o to 1. That operand never takes code 2'b10. It still takes the memory-stage value (code 2'b01) if the memory stage also matches, and the register-file value otherwise.
- R9: In stall-only mode (fwd_en_i=0), any dependency on either stage sets stall_o to 1, both forward codes stay 2'b00, and both values pass through from the register file.
- R10: In forwarding mode, stall_o is 1 only when an execute-stage load matches a needed operand.
- R11: The two operands are resolved independently. In one cycle, rs can be forwarded from one stage while rt is forwarded from the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fwd_en_i | input | 1 | 1 selects forwarding with stalls, 0 selects stall-only |
| rs_idx_i | input | 5 | Decode-stage rs register index |
| rt_idx_i | input | 5 | Decode-stage rt register index |
| need_rs_i | input | 1 | Decoded instruction reads rs |
| need_rt_i | input | 1 | Decoded instruction reads rt |
| rf_rs_val_i | input | 32 | Register-file value read for rs |
| rf_rt_val_i | input | 32 | Register-file value read for rt |
| ex_wr_en_i | input | 1 | Execute-stage instruction writes a register |
| ex_dst_i | input | 5 | Execute-stage destination index |
| ex_is_load_i | input | 1 | Execute-stage instruction is a load |
| ex_alu_val_i | input | 32 | Execute-stage ALU result |
| mem_wr_en_i | input | 1 | Memory-stage instruction writes a register |
| mem_dst_i | input | 5 | Memory-stage destination index |
| mem_wb_val_i | input | 32 | Value the memory stage will write back |
| rs_val_o | output | 32 | Resolved rs operand |
| rt_val_o | output | 32 | Resolved rt operand |
| rs_fwd_o | output | 2 | rs source: 00 register file, 01 memory stage, 10 execute stage |
| rt_fwd_o | output | 2 | rt source, same encoding as rs_fwd_o |
| stall_o | output | 1 | Hold decode for one cycle |

## Verification
The hardest case to reach is an execute-stage load that matches one operand while the memory stage matches the other operand or the same one. In that case stall, the memory forward and the blocked execute forward must all appear together. Random cycles alone rarely produce it, so the stimulus draws register indices from a range of only four values and sets the load flag on about half the cycles. Directed cases also set up exact overlaps of a load with a memory match, including a match on register 0 and a match on an operand that is not needed.

// File: rtl/hfu_pkg.sv
package hfu_pkg;
  localparam int unsigned NUM_REGS = 32;
  localparam int unsigned XLEN     = 32;

  typedef enum logic [1:0] {
    FWD_NONE = 2'b00,
    FWD_MEM  = 2'b01,
    FWD_EX   = 2'b10
  } fwd_src_e;
endpackage

// File: rtl/hfu_dep_detect.sv
module hfu_dep_detect #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src_idx_i,
  input  logic          src_need_i,
  input  logic          dst_wr_i,
  input  logic [AW-1:0] dst_idx_i,
  output logic          hit_o
);
  // register 0 is a sink, never a producer
  logic dst_live;
  assign dst_live = dst_wr_i && (dst_idx_i != '0);
  assign hit_o    = src_need_i && dst_live && (dst_idx_i == src_idx_i);
endmodule

// File: rtl/hfu_operand_sel.sv
module hfu_operand_sel
  import hfu_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          fwd_en_i,
  input  logic          hit_ex_i,
  input  logic          hit_mem_i,
  input  logic          ex_is_load_i,
  input  logic [DW-1:0] rf_val_i,
  input  logic [DW-1:0] ex_val_i,
  input  logic [DW-1:0] mem_val_i,
  output logic [DW-1:0] val_o,
  output fwd_src_e      src_o,
  output logic          stall_o
);
  logic ex_ok;
  assign ex_ok = hit_ex_i && !ex_is_load_i;

  always_comb begin
    val_o   = rf_val_i;
    src_o   = FWD_NONE;
    stall_o = 1'b0;
    if (fwd_en_i) begin
      if (ex_ok) begin
        val_o = ex_val_i;
        src_o = FWD_EX;
      end else if (hit_mem_i) begin
        val_o = mem_val_i;
        src_o = FWD_MEM;
      end
      stall_o = hit_ex_i && ex_is_load_i;
    end else begin
      stall_o = hit_ex_i || hit_mem_i;
    end
  end
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
  import hfu_pkg::*;
#(
  parameter int unsigned NREG = hfu_pkg::NUM_REGS,
  parameter int unsigned DW   = hfu_pkg::XLEN,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          fwd_en_i,
  input  logic [AW-1:0] rs_idx_i,
  input  logic [AW-1:0] rt_idx_i,
  input  logic          need_rs_i,
  input  logic          need_rt_i,
  input  logic [DW-1:0] rf_rs_val_i,
  input  logic [DW-1:0] rf_rt_val_i,
  input  logic          ex_wr_en_i,
  input  logic [AW-1:0] ex_dst_i,
  input  logic          ex_is_load_i,
  input  logic [DW-1:0] ex_alu_val_i,
  input  logic          mem_wr_en_i,
  input  logic [AW-1:0] mem_dst_i,
  input  logic [DW-1:0] mem_wb_val_i,
  output logic [DW-1:0] rs_val_o,
  output logic [DW-1:0] rt_val_o,
  output logic [1:0]    rs_fwd_o,
  output logic [1:0]    rt_fwd_o,
  output logic          stall_o
);
  localparam int unsigned NOPS = 2;  // 0: rs, 1: rt

  logic [NOPS-1:0][AW-1:0] op_idx;
  logic [NOPS-1:0]         op_need;
  logic [NOPS-1:0][DW-1:0] op_rf;
  logic [NOPS-1:0][DW-1:0] op_val;
  fwd_src_e [NOPS-1:0]     op_src;
  logic [NOPS-1:0]         op_hit_ex;
  logic [NOPS-1:0]         op_hit_mem;
  logic [NOPS-1:0]         op_stall;

  assign op_idx[0]  = rs_idx_i;
  assign op_idx[1]  = rt_idx_i;
  assign op_need[0] = need_rs_i;
  assign op_need[1] = need_rt_i;
  assign op_rf[0]   = rf_rs_val_i;
  assign op_rf[1]   = rf_rt_val_i;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    hfu_dep_detect #(.AW(AW)) u_dep_ex (
      .src_idx_i  (op_idx[g]),
      .src_need_i (op_need[g]),
      .dst_wr_i   (ex_wr_en_i),
      .dst_idx_i  (ex_dst_i),
      .hit_o      (op_hit_ex[g])
    );
    hfu_dep_detect #(.AW(AW)) u_dep_mem (
      .src_idx_i  (op_idx[g]),
      .src_need_i (op_need[g]),
      .dst_wr_i   (mem_wr_en_i),
      .dst_idx_i  (mem_dst_i),
      .hit_o      (op_hit_mem[g])
    );
    hfu_operand_sel #(.DW(DW)) u_sel (
      .fwd_en_i     (fwd_en_i),
      .hit_ex_i     (op_hit_ex[g]),
      .hit_mem_i    (op_hit_mem[g]),
      .ex_is_load_i (ex_is_load_i),
      .rf_val_i     (op_rf[g]),
      .ex_val_i     (ex_alu_val_i),
      .mem_val_i    (mem_wb_val_i),
      .val_o        (op_val[g]),
      .src_o        (op_src[g]),
      .stall_o      (op_stall[g])
    );
  end

  assign rs_val_o = op_val[0];
  assign rt_val_o = op_val[1];
  assign rs_fwd_o = op_src[0];
  assign rt_fwd_o = op_src[1];
  assign stall_o  = |op_stall;
endmodule

// File: rtl/fwd_hazard_unit_chk.sv
module fwd_hazard_unit_chk #(
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 32
) (
  input logic          fwd_en_i,
  input logic          need_rs_i,
  input logic          need_rt_i,
  input logic [DW-1:0] rf_rs_val_i,
  input logic [DW-1:0] rf_rt_val_i,
  input logic          ex_wr_en_i,
  input logic [AW-1:0] ex_dst_i,
  input logic          ex_is_load_i,
  input logic [DW-1:0] ex_alu_val_i,
  input logic          mem_wr_en_i,
  input logic [AW-1:0] mem_dst_i,
  input logic [DW-1:0] mem_wb_val_i,
  input logic [DW-1:0] rs_val_o,
  input logic [DW-1:0] rt_val_o,
  input logic [1:0]    rs_fwd_o,
  input logic [1:0]    rt_fwd_o,
  input logic          stall_o
);
  logic ex_dead, mem_dead;
  assign ex_dead  = !ex_wr_en_i || (ex_dst_i == '0);
  assign mem_dead = !mem_wr_en_i || (mem_dst_i == '0);

  always_comb begin
    AST_PASS_RS: assert (rs_fwd_o != 2'b00 || rs_val_o == rf_rs_val_i); // R1
    AST_PASS_RT: assert (rt_fwd_o != 2'b00 || rt_val_o == rf_rt_val_i); // R1
    AST_DEAD_STAGES_QUIET: assert (!(ex_dead && mem_dead) || (!stall_o && rs_fwd_o == 2'b00 && rt_fwd_o == 2'b00)); // R2
    AST_UNNEEDED_QUIET: assert (need_rs_i || need_rt_i || (!stall_o && rs_fwd_o == 2'b00 && rt_fwd_o == 2'b00)); // R4
    AST_MEM_VALUE_RS: assert (rs_fwd_o != 2'b01 || rs_val_o == mem_wb_val_i); // R5
    AST_EX_VALUE_RS: assert (rs_fwd_o != 2'b10 || rs_val_o == ex_alu_val_i); // R6
    AST_EX_VALUE_RT: assert (rt_fwd_o != 2'b10 || rt_val_o == ex_alu_val_i); // R6
    AST_NO_EX_FWD_OF_LOAD: assert (!ex_is_load_i || (rs_fwd_o != 2'b10 && rt_fwd_o != 2'b10)); // R8
    AST_STALL_ONLY_NO_FWD: assert (fwd_en_i || (rs_fwd_o == 2'b00 && rt_fwd_o == 2'b00)); // R9
    AST_FWD_STALL_NEEDS_LOAD: assert (!fwd_en_i || !stall_o || (ex_is_load_i && !ex_dead)); // R10
  end
endmodule

bind fwd_hazard_unit fwd_hazard_unit_chk #(.AW(AW), .DW(DW)) u_chk (
  .fwd_en_i     (fwd_en_i),
  .need_rs_i    (need_rs_i),
  .need_rt_i    (need_rt_i),
  .rf_rs_val_i  (rf_rs_val_i),
  .rf_rt_val_i  (rf_rt_val_i),
  .ex_wr_en_i   (ex_wr_en_i),
  .ex_dst_i     (ex_dst_i),
  .ex_is_load_i (ex_is_load_i),
  .ex_alu_val_i (ex_alu_val_i),
  .mem_wr_en_i  (mem_wr_en_i),
  .mem_dst_i    (mem_dst_i),
  .mem_wb_val_i (mem_wb_val_i),
  .rs_val_o     (rs_val_o),
  .rt_val_o     (rt_val_o),
  .rs_fwd_o     (rs_fwd_o),
  .rt_fwd_o     (rt_fwd_o),
  .stall_o      (stall_o)
);

// File: tb/fwd_hazard_unit_test.sv
module fwd_hazard_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 1'b0;

  logic        fwd_en;
  logic [4:0]  rs_idx, rt_idx, ex_dst, mem_dst;
  logic        need_rs, need_rt, ex_wr, ex_ld, mem_wr;
  logic [31:0] rf_rs, rf_rt, ex_val, mem_val;
  logic [31:0] rs_val, rt_val;
  logic [1:0]  rs_fwd, rt_fwd;
  logic        stall;

  always #10 clk = ~clk;  // 50 MHz

  fwd_hazard_unit uut (
    .fwd_en_i(fwd_en), .rs_idx_i(rs_idx), .rt_idx_i(rt_idx),
    .need_rs_i(need_rs), .need_rt_i(need_rt),
    .rf_rs_val_i(rf_rs), .rf_rt_val_i(rf_rt),
    .ex_wr_en_i(ex_wr), .ex_dst_i(ex_dst), .ex_is_load_i(ex_ld), .ex_alu_val_i(ex_val),
    .mem_wr_en_i(mem_wr), .mem_dst_i(mem_dst), .mem_wb_val_i(mem_val),
    .rs_val_o(rs_val), .rt_val_o(rt_val), .rs_fwd_o(rs_fwd), .rt_fwd_o(rt_fwd),
    .stall_o(stall)
  );

  task automatic drive(input bit f, input int rs, input int rt, input bit nrs, input bit nrt,
                       input bit ew, input int ed, input bit el,
                       input bit mw, input int md);
    @(posedge clk);
    fwd_en = f; rs_idx = 5'(rs); rt_idx = 5'(rt); need_rs = nrs; need_rt = nrt;
    ex_wr = ew; ex_dst = 5'(ed); ex_ld = el; mem_wr = mw; mem_dst = 5'(md);
    rf_rs = 32'h1000_0000 | 32'($urandom_range(0, 65535));
    rf_rt = 32'h2000_0000 | 32'($urandom_range(0, 65535));
    ex_val = 32'hE000_0000 | 32'($urandom_range(0, 65535));
    mem_val = 32'hA000_0000 | 32'($urandom_range(0, 65535));
  endtask

  // behavioural reference: one operand
  task automatic ref_op(input int idx, input bit need, output logic [31:0] v,
                        output logic [1:0] c, output bit st, input logic [31:0] rf);
    bit he, hm;
    he = need && ex_wr && ex_dst != 0 && int'(ex_dst) == idx;
    hm = need && mem_wr && mem_dst != 0 && int'(mem_dst) == idx;
    v = rf; c = 2'b00; st = 0;
    if (!fwd_en) st = he || hm;
    else begin
      st = he && ex_ld;
      if (he && !ex_ld) begin v = ex_val; c = 2'b10; end
      else if (hm) begin v = mem_val; c = 2'b01; end
    end
  endtask

  task automatic compare(input string req);
    logic [31:0] ers, ert; logic [1:0] crs, crt; bit s1, s2;
    @(negedge clk);
    ref_op(int'(rs_idx), need_rs, ers, crs, s1, rf_rs);
    ref_op(int'(rt_idx), need_rt, ert, crt, s2, rf_rt);
    n_checks++;
    if (rs_val !== ers || rt_val !== ert || rs_fwd !== crs || rt_fwd !== crt || stall !== (s1 || s2)) begin
      n_errors++;
      $display("FAIL %s: act rs=%h/%b rt=%h/%b st=%b exp rs=%h/%b rt=%h/%b st=%b",
               req, rs_val, rs_fwd, rt_val, rt_fwd, stall, ers, crs, ert, crt, s1 || s2);
    end
  endtask

  task automatic expect_codes(input string req, input logic [1:0] ers, input logic [1:0] ert,
                              input logic est);
    n_checks++;
    if (rs_fwd !== ers || rt_fwd !== ert || stall !== est) begin
      n_errors++;
      $display("FAIL %s: act codes=%b/%b st=%b exp codes=%b/%b st=%b",
               req, rs_fwd, rt_fwd, stall, ers, ert, est);
    end
  endtask

  initial begin
    drive(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    compare("R1 reset idle"); expect_codes("R1 reset idle", 2'b00, 2'b00, 0);
    drive(1, 3, 4, 1, 1, 1, 5, 0, 1, 6);  compare("R1");  expect_codes("R1", 2'b00, 2'b00, 0);
    drive(1, 0, 0, 1, 1, 1, 0, 0, 1, 0);  compare("R2");  expect_codes("R2", 2'b00, 2'b00, 0);
    drive(0, 0, 0, 1, 1, 1, 0, 1, 1, 0);  compare("R2");  expect_codes("R2 stall-only", 2'b00, 2'b00, 0);
    drive(1, 7, 7, 1, 1, 0, 7, 0, 0, 7);  compare("R3");  expect_codes("R3", 2'b00, 2'b00, 0);
    drive(1, 9, 8, 1, 0, 1, 8, 1, 1, 8);  compare("R4");  expect_codes("R4 rt unneeded", 2'b00, 2'b00, 0);
    drive(0, 9, 8, 0, 1, 1, 9, 0, 1, 9);  compare("R4");  expect_codes("R4 rs unneeded", 2'b00, 2'b00, 0);
    drive(1, 11, 12, 1, 1, 0, 0, 0, 1, 12); compare("R5"); expect_codes("R5", 2'b00, 2'b01, 0);
    drive(1, 11, 12, 1, 1, 1, 11, 0, 0, 0); compare("R6"); expect_codes("R6", 2'b10, 2'b00, 0);
    drive(1, 13, 13, 1, 1, 1, 13, 0, 1, 13); compare("R7"); expect_codes("R7", 2'b10, 2'b10, 0);
    drive(1, 14, 15, 1, 1, 1, 14, 1, 1, 14); compare("R8"); expect_codes("R8 mem beneath load", 2'b01, 2'b00, 1);
    drive(1, 14, 15, 1, 1, 1, 15, 1, 0, 0); compare("R8"); expect_codes("R8 load only", 2'b00, 2'b00, 1);
    drive(0, 16, 17, 1, 1, 0, 0, 0, 1, 17); compare("R9"); expect_codes("R9 mem", 2'b00, 2'b00, 1);
    drive(0, 16, 17, 1, 1, 1, 16, 0, 0, 0); compare("R9"); expect_codes("R9 ex", 2'b00, 2'b00, 1);
    drive(1, 18, 19, 1, 1, 1, 18, 0, 1, 19); compare("R10"); expect_codes("R10", 2'b10, 2'b01, 0);
    drive(1, 20, 21, 1, 1, 1, 21, 0, 1, 20); compare("R11"); expect_codes("R11", 2'b01, 2'b10, 0);
    for (int i = 0; i < 3000; i++) begin
      drive(bit'($urandom_range(0, 3) != 0),
            $urandom_range(0, 3), $urandom_range(0, 3),
            bit'($urandom_range(0, 1)), bit'($urandom_range(0, 3) != 0),
            bit'($urandom_range(0, 3) != 0), $urandom_range(0, 3), bit'($urandom_range(0, 1)),
            bit'($urandom_range(0, 3) != 0), $urandom_range(0, 3));
      compare("R7 R8 R10 R11 random");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: act hung exp finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule